// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block sits on a byte-wide register bus and turns software writes into erase requests for an on-chip flash array. Software first arms an operation by writing a setup register, then writes a key byte to the command register. The page key arms nothing by itself: it starts a page erase only when the page-number register has been freshly written. The mass key starts a whole-array erase only when the mass-enable register has been freshly written and the debug-enable input is high.

When a command is accepted, the block raises a one-cycle request pulse toward the flash, along with a stable page number, and holds `busy` until the flash returns a one-cycle `erase_done` pulse. Every accepted erase uses up its arming, so each new erase needs a new setup write. The request interface has no back-pressure. The flash must take a request pulse in the cycle it appears, and `busy` is the only flow control: while it is high, the block discards command writes. The register bus is a plain strobe with no stall. The page-number register can be read back through a combinational read port.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy`, `page_req` and `mass_req` are 0, `erase_page` is 0, and the page-number register reads back 0x00.
- R2: A read at `PAGE_ADDR` returns the last byte written there, including bit 7. A read at `CMD_ADDR` or at `MEN_ADDR` returns 0x00.
- R3: A write of 0x55 to `CMD_ADDR` while idle with the page armed is accepted. In the cycle after that write, `page_req` is 1 for exactly one cycle and `busy` becomes 1.
- R4: A page erase consumes the page arming. A second 0x55 that is not preceded by a new write to `PAGE_ADDR` has no effect.
- R5: A write of 0xAA to `CMD_ADDR` while idle, with the mass erase armed and `dbg_en` high, is accepted. In the cycle after that write, `mass_req` is 1 for exactly one cycle and `busy` becomes 1, while `page_req` stays 0.
- R6: A 0xAA command is ignored when the mass erase is not armed or when `dbg_en` is low. An ignored 0xAA leaves the mass arming in place.
- R7: A mass erase consumes the mass arming. A second 0xAA with no new write to `MEN_ADDR` has no effect.
- R8: Any byte other than 0x55 or 0xAA written to `CMD_ADDR` produces no request, leaves `busy` at 0, and consumes no arming.
- R9: While `busy` is 1, command writes are ignored and consume no arming. `busy` stays 1 until `erase_done` is sampled high, and it falls in the following cycle.
- R10: An `erase_done` pulse while idle has no effect.
- R11: `erase_page` carries bits [6:0] of the page-number register as captured at acceptance, ignores bit 7, and stays stable while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Combinational read data |
| dbg_en | input | 1 | Debug port enabled; required for mass erase |
| erase_done | input | 1 | One-cycle completion pulse from the flash |
| page_req | output | 1 | One-cycle page-erase request |
| mass_req | output | 1 | One-cycle mass-erase request |
| erase_page | output | PAGE_W | Page number for the page erase |
| busy | output | 1 | Erase in progress |

## Verification
The bench builds the block with its default values: `ADDR_W` = 8, `PAGE_W` = 7, and the setup and command registers at three adjacent addresses. The 7-bit page width puts the top page, 127, within reach, and it lets the bench check that page bit 7, written as a 1, is readable but dropped from the page number sent to the flash. With adjacent addresses, an off-by-one in address decode would arm or fire the wrong register, which the arming and consumption checks then expose.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] KEY_PAGE = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_MASS = 8'hAA;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PAGE = 2'd1,
    OP_MASS = 2'd2
  } op_e;
endpackage

// File: rtl/fes_regs.sv
module fes_regs
  import fes_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] MEN_ADDR  = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              consume_page,
  input  logic              consume_mass,
  output logic [BYTE_W-1:0] page_reg,
  output logic              page_armed,
  output logic              mass_armed,
  output logic [BYTE_W-1:0] rd_data
);
  logic hit_page, hit_men;

  assign hit_page = wr_en && (wr_addr == PAGE_ADDR);
  assign hit_men  = wr_en && (wr_addr == MEN_ADDR);

  // Page number byte, full width stored so it reads back as written
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        page_reg <= '0;
    else if (hit_page) page_reg <= wr_data;
  end

  // Arming flags: set by a setup write, cleared when an erase uses them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_armed <= 1'b0;
      mass_armed <= 1'b0;
    end else begin
      if (hit_page)          page_armed <= 1'b1;
      else if (consume_page) page_armed <= 1'b0;
      if (hit_men)           mass_armed <= 1'b1;
      else if (consume_mass) mass_armed <= 1'b0;
    end
  end

  // Only the page register is readable; everything else reads zero
  always_comb begin
    rd_data = '0;
    if (rd_addr == PAGE_ADDR) rd_data = page_reg;
  end
endmodule

// File: rtl/fes_decode.sv
module fes_decode
  import fes_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h10
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              busy,
  input  logic              page_armed,
  input  logic              mass_armed,
  input  logic              dbg_en,
  output op_e               op,
  output logic              consume_page,
  output logic              consume_mass
);
  logic cmd_wr, key_page, key_mass;

  assign cmd_wr   = wr_en && (wr_addr == CMD_ADDR) && !busy;
  assign key_page = (wr_data == KEY_PAGE);
  assign key_mass = (wr_data == KEY_MASS);

  always_comb begin
    op = OP_NONE;
    if (cmd_wr && key_page && page_armed)
      op = OP_PAGE;
    else if (cmd_wr && key_mass && mass_armed && dbg_en)
      op = OP_MASS;
  end

  assign consume_page = (op == OP_PAGE);
  assign consume_mass = (op == OP_MASS);
endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
#(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op,
  input  logic [PAGE_W-1:0] page_num,
  input  logic              erase_done,
  output logic              busy,
  output logic              page_req,
  output logic              mass_req,
  output logic [PAGE_W-1:0] erase_page
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      page_req   <= 1'b0;
      mass_req   <= 1'b0;
      erase_page <= '0;
    end else begin
      page_req <= 1'b0;
      mass_req <= 1'b0;
      if (busy) begin
        if (erase_done) busy <= 1'b0;
      end else if (op != OP_NONE) begin
        busy <= 1'b1;
        if (op == OP_PAGE) begin
          page_req   <= 1'b1;
          erase_page <= page_num;
        end else begin
          mass_req <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import fes_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 7,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 8'h11,
  parameter logic [ADDR_W-1:0] MEN_ADDR  = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              dbg_en,
  input  logic              erase_done,
  output logic              page_req,
  output logic              mass_req,
  output logic [PAGE_W-1:0] erase_page,
  output logic              busy
);
  logic [BYTE_W-1:0] page_reg;
  logic page_armed, mass_armed, consume_page, consume_mass;
  op_e  op;

  fes_regs #(.ADDR_W(ADDR_W), .PAGE_ADDR(PAGE_ADDR), .MEN_ADDR(MEN_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .consume_page(consume_page), .consume_mass(consume_mass),
    .page_reg(page_reg), .page_armed(page_armed), .mass_armed(mass_armed),
    .rd_data(rd_data)
  );

  fes_decode #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
    .page_armed(page_armed), .mass_armed(mass_armed), .dbg_en(dbg_en),
    .op(op), .consume_page(consume_page), .consume_mass(consume_mass)
  );

  fes_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op), .page_num(page_reg[PAGE_W-1:0]),
    .erase_done(erase_done), .busy(busy), .page_req(page_req),
    .mass_req(mass_req), .erase_page(erase_page)
  );
endmodule

// File: rtl/fes_chk.sv
module fes_chk #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 7,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              dbg_en,
  input logic              erase_done,
  input logic              page_req,
  input logic              mass_req,
  input logic [PAGE_W-1:0] erase_page,
  input logic              busy
);
  // R3 R5: busy only rises after a key byte on the command address
  a_r3_rise_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && wr_addr == CMD_ADDR &&
                          (wr_data == 8'h55 || wr_data == 8'hAA)));

  // R5: mass request only with debug enabled at the command
  a_r5_mass_needs_dbg: assert property (@(posedge clk) disable iff (!rst_n)
    mass_req |-> $past(dbg_en));

  // R9: no request follows a busy cycle, requests are exclusive
  a_r9_no_req_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !page_req && !mass_req);
  a_r9_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({page_req, mass_req}));

  // R9: done while busy clears busy in the next cycle
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy && erase_done |=> !busy);

  // R10: busy never rises on a done pulse alone
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && erase_done && !wr_en |=> !busy);

  // R11: page number held while an erase runs
  a_r11_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !page_req |-> $stable(erase_page));
endmodule

bind flash_erase_seq fes_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CMD_ADDR(CMD_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .dbg_en(dbg_en), .erase_done(erase_done), .page_req(page_req),
  .mass_req(mass_req), .erase_page(erase_page), .busy(busy)
);

// File: tb/tb_flash_erase_seq.sv
module tb_flash_erase_seq;
  localparam int ADDR_W = 8;
  localparam int PAGE_W = 7;
  localparam logic [7:0] CMD  = 8'h10;
  localparam logic [7:0] PAGE = 8'h11;
  localparam logic [7:0] MEN  = 8'h12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, dbg_en = 1'b0, erase_done = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0, rd_data;
  logic page_req, mass_req, busy;
  logic [PAGE_W-1:0] erase_page;
  int n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  flash_erase_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbg_en(dbg_en), .erase_done(erase_done),
    .page_req(page_req), .mass_req(mass_req), .erase_page(erase_page), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Write lasts one edge; returns at the negedge after it, where results show
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 page_req", page_req, 0);
    chk("R1 mass_req", mass_req, 0);
    chk("R1 erase_page", erase_page, 0);
    rd_addr = PAGE; #1;
    chk("R1 page readback", rd_data, 8'h00);
  endtask

  task automatic t_readback();
    wr(PAGE, 8'h93);
    rd_addr = PAGE; #1;
    chk("R2 page readback", rd_data, 8'h93);
    rd_addr = CMD; #1;
    chk("R2 cmd reads zero", rd_data, 0);
    rd_addr = MEN; #1;
    chk("R2 men reads zero", rd_data, 0);
  endtask

  task automatic t_page_and_busy();
    wr(CMD, 8'h55);
    chk("R3 page_req", page_req, 1);
    chk("R3 busy", busy, 1);
    chk("R11 bit7 dropped", erase_page, 7'h13);
    @(negedge clk);
    chk("R3 single pulse", page_req, 0);
    wr(PAGE, 8'h05);
    wr(CMD, 8'h55);
    chk("R9 ignored while busy", page_req, 0);
    chk("R11 stable while busy", erase_page, 7'h13);
    repeat (3) @(negedge clk);
    chk("R9 busy holds", busy, 1);
    done_pulse();
    chk("R9 busy cleared", busy, 0);
    wr(CMD, 8'h55);
    chk("R9 arming kept", page_req, 1);
    chk("R11 new page", erase_page, 7'h05);
    done_pulse();
  endtask

  task automatic t_rearm();
    wr(CMD, 8'h55);
    chk("R4 no rearm req", page_req, 0);
    chk("R4 no rearm busy", busy, 0);
  endtask

  task automatic t_other_keys();
    wr(PAGE, 8'h7F);
    wr(CMD, 8'h5A);
    chk("R8 5A", page_req | mass_req | busy, 0);
    wr(CMD, 8'h00);
    chk("R8 00", page_req | mass_req | busy, 0);
    wr(CMD, 8'hFF);
    chk("R8 FF", page_req | mass_req | busy, 0);
    wr(CMD, 8'h55);
    chk("R8 arming survives", page_req, 1);
    chk("R11 top page", erase_page, 7'h7F);
    done_pulse();
  endtask

  task automatic t_mass();
    dbg_en = 1'b1;
    wr(CMD, 8'hAA);
    chk("R6 unarmed", mass_req | busy, 0);
    wr(MEN, 8'h01);
    dbg_en = 1'b0;
    wr(CMD, 8'hAA);
    chk("R6 dbg low", mass_req | busy, 0);
    dbg_en = 1'b1;
    wr(CMD, 8'hAA);
    chk("R5 mass_req", mass_req, 1);
    chk("R5 busy", busy, 1);
    chk("R5 no page_req", page_req, 0);
    @(negedge clk);
    chk("R5 single pulse", mass_req, 0);
    done_pulse();
    wr(CMD, 8'hAA);
    chk("R7 consumed", mass_req | busy, 0);
  endtask

  task automatic t_idle_done();
    done_pulse();
    chk("R10 idle done busy", busy, 0);
    chk("R10 idle done req", page_req | mass_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_page_and_busy();
    t_rearm();
    t_other_keys();
    t_mass();
    t_idle_done();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule